// File: doc/BRIEF.md
# Switch Reset and Init Sequencer

This block brings up an external Ethernet switch on a board that has no working power-on reset circuit of its own. On a start pulse it drives the switch's reset-control line through three timed phases: high, then low, then high again. Each phase is counted in millisecond ticks that arrive on an input. While the line is low and during the final high phase, it drives fixed strap levels onto the serial clock and data pins. Once the line stays high it releases those pins.

After the release it programs a default configuration by handing seven register writes, one at a time, to a serial register access master. Six writes go to the per-port configuration registers. The sixth port also gets its tagging bit set. The last write goes to the VLAN mode register. A one-cycle done pulse follows the last write. The serial framing belongs to the access master and is outside this block.

Top module: `swrst_init_seq`

## Requirements
- R1: After reset, rc_o is 1, pins_oe_o is 0, wr_valid_o is 0 and done_o is 0.
- R2: A start_i pulse in idle begins the first high phase. rc_o stays 1 and pins_oe_o stays 0 for exactly HI1_MS ticks, where a tick is a cycle with ms_tick_i high.
- R3: rc_o is then 0 for exactly LO_MS ticks.
- R4: Whenever pins_oe_o is 1, sck_o is 1 and sdo_o is 0. pins_oe_o is 1 through the whole low phase and the final high phase.
- R5: The final high phase keeps rc_o at 1 for exactly HI2_MS ticks. At its end pins_oe_o drops to 0 and rc_o stays at 1 from then on.
- R6: Six port writes are requested next, at addresses 0x01, 0x03, 0x05, 0x07, 0x08 and 0x09 in that order. Each carries data 0x800F, except the sixth, which carries 0x801F (bit 4, tagging, set).
- R7: The seventh and last write goes to address 0x11 with data 0xFF30.
- R8: A write request holds wr_valid_o high with wr_addr_o and wr_data_o unchanged until a cycle with wr_done_i high. The next request appears in the cycle after that.
- R9: done_o is high for exactly one cycle, in the cycle after wr_done_i accepts the last write. wr_valid_o is 0 in that cycle.
- R10: start_i is ignored while a sequence is running. A start_i after done_o runs the whole sequence again.
- R11: ms_tick_i has no effect while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin the reset and init sequence |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| rc_o | output | 1 | Reset-control line to the switch |
| sck_o | output | 1 | Strap level for the serial clock pin |
| sdo_o | output | 1 | Strap level for the serial data pin |
| pins_oe_o | output | 1 | Output enable for the chip-select, clock and data pins |
| wr_addr_o | output | AW | Register write address |
| wr_data_o | output | DW | Register write data |
| wr_valid_o | output | 1 | Register write request |
| wr_done_i | input | 1 | Access master finished the current write |
| done_o | output | 1 | One-cycle pulse after the last write |

## Verification
The write list is walked from a vector table that pairs each expected address and data word with a different wait before wr_done_i arrives. Zero-cycle acknowledgements exercise back-to-back advance, and long waits show that the request holds steady. Each phase boundary is probed one tick before and on the tick that ends it, which separates off-by-one phase lengths from correct ones. Start pulses and ticks given mid-sequence and in idle show that they are ignored. A second run after done_o shows that the sequencer rearms.

// File: rtl/swrst_init_seq.sv
module swrst_init_seq #(
  parameter int          HI1_MS    = 20,
  parameter int          LO_MS     = 100,
  parameter int          HI2_MS    = 30,
  parameter int          AW        = 8,
  parameter int          DW        = 16,
  parameter logic [15:0] PORT_CFG  = 16'h800F,
  parameter int          TAG_BIT   = 4,
  parameter logic [7:0]  MODE_ADDR = 8'h11,
  parameter logic [15:0] MODE_VAL  = 16'hFF30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          ms_tick_i,
  output logic          rc_o,
  output logic          sck_o,
  output logic          sdo_o,
  output logic          pins_oe_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          wr_valid_o,
  input  logic          wr_done_i,
  output logic          done_o
);
  localparam int MAXP = (HI1_MS > LO_MS) ? ((HI1_MS > HI2_MS) ? HI1_MS : HI2_MS)
                                         : ((LO_MS > HI2_MS) ? LO_MS : HI2_MS);
  localparam int CW   = $clog2(MAXP + 1);
  localparam int NWR  = 7;
  localparam int IW   = 3;
  localparam logic [CW-1:0] HI1_END = CW'(HI1_MS - 1);
  localparam logic [CW-1:0] LO_END  = CW'(LO_MS - 1);
  localparam logic [CW-1:0] HI2_END = CW'(HI2_MS - 1);
  localparam logic [IW-1:0] LAST    = IW'(NWR - 1);
  localparam logic [IW-1:0] TAGGED  = IW'(NWR - 2);

  typedef enum logic [2:0] {S_IDLE, S_HI1, S_LO, S_HI2, S_WR} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      idx    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          st  <= S_HI1;
          cnt <= '0;
        end
        S_HI1: if (ms_tick_i) begin
          if (cnt == HI1_END) begin st <= S_LO; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        S_LO: if (ms_tick_i) begin
          if (cnt == LO_END) begin st <= S_HI2; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        S_HI2: if (ms_tick_i) begin
          if (cnt == HI2_END) begin st <= S_WR; cnt <= '0; idx <= '0; end
          else cnt <= cnt + 1'b1;
        end
        S_WR: if (wr_done_i) begin
          if (idx == LAST) begin st <= S_IDLE; done_q <= 1'b1; end
          else idx <= idx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rc_o       = (st != S_LO);
  assign pins_oe_o  = (st == S_LO) || (st == S_HI2);
  assign sck_o      = pins_oe_o;
  assign sdo_o      = 1'b0;
  assign wr_valid_o = (st == S_WR);
  assign done_o     = done_q;

  always_comb begin
    if (idx == LAST)      wr_addr_o = AW'(MODE_ADDR);
    else if (idx < 3'd4)  wr_addr_o = AW'({idx, 1'b1});
    else                  wr_addr_o = AW'(idx) + AW'(4);
    if (idx == LAST)        wr_data_o = DW'(MODE_VAL);
    else if (idx == TAGGED) wr_data_o = DW'(PORT_CFG) | (DW'(1) << TAG_BIT);
    else                    wr_data_o = DW'(PORT_CFG);
  end
endmodule

// File: rtl/swrst_init_seq_chk.sv
module swrst_init_seq_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rc_o,
  input logic          sck_o,
  input logic          sdo_o,
  input logic          pins_oe_o,
  input logic [AW-1:0] wr_addr_o,
  input logic [DW-1:0] wr_data_o,
  input logic          wr_valid_o,
  input logic          wr_done_i,
  input logic          done_o
);
  // R4
  rc_low_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rc_o |-> pins_oe_o);
  // R4
  strap_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pins_oe_o |-> (sck_o && !sdo_o));
  // R5
  write_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (rc_o && !pins_oe_o));
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_done_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9
  done_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !wr_valid_o);
endmodule

bind swrst_init_seq swrst_init_seq_chk #(.AW(AW), .DW(DW)) chk_i (.*);

// File: tb/swrst_init_seq_tb_top.sv
module swrst_init_seq_tb_top;
  localparam int HI1 = 3, LO = 5, HI2 = 4;
  localparam int NV = 7;
  localparam logic [27:0] VEC [NV] = '{
    {8'h01, 16'h800F, 4'd0},
    {8'h03, 16'h800F, 4'd3},
    {8'h05, 16'h800F, 4'd0},
    {8'h07, 16'h800F, 4'd7},
    {8'h08, 16'h800F, 4'd1},
    {8'h09, 16'h801F, 4'd0},
    {8'h11, 16'hFF30, 4'd5}
  };

  logic clk = 0, rst_n = 0, start_i = 0, ms_tick_i = 0, wr_done_i = 0;
  logic rc_o, sck_o, sdo_o, pins_oe_o, wr_valid_o, done_o;
  logic [7:0]  wr_addr_o;
  logic [15:0] wr_data_o;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  swrst_init_seq #(.HI1_MS(HI1), .LO_MS(LO), .HI2_MS(HI2)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick_i = 1;
      @(negedge clk) ms_tick_i = 0;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  task automatic run_phases();
    pulse_start();
    chk(rc_o == 1 && pins_oe_o == 0, "R2", {rc_o, pins_oe_o}, 2'b10);
    tick(HI1 - 1);
    pulse_start();
    chk(rc_o == 1 && pins_oe_o == 0, "R2 R10", {rc_o, pins_oe_o}, 2'b10);
    tick(1);
    chk(rc_o == 0, "R2 R3", rc_o, 0);
    chk(pins_oe_o && sck_o && !sdo_o, "R4", {pins_oe_o, sck_o, sdo_o}, 3'b110);
    tick(LO - 1);
    chk(rc_o == 0 && pins_oe_o, "R3 R4", {rc_o, pins_oe_o}, 2'b01);
    tick(1);
    chk(rc_o == 1 && pins_oe_o && sck_o && !sdo_o, "R3 R4", {rc_o, pins_oe_o, sck_o, sdo_o}, 4'b1110);
    tick(HI2 - 1);
    chk(rc_o == 1 && pins_oe_o && !wr_valid_o, "R5", {rc_o, pins_oe_o, wr_valid_o}, 3'b110);
    tick(1);
    chk(rc_o == 1 && !pins_oe_o && wr_valid_o, "R5", {rc_o, pins_oe_o, wr_valid_o}, 3'b101);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rc_o == 1 && !pins_oe_o && !wr_valid_o && !done_o, "R1",
        {rc_o, pins_oe_o, wr_valid_o, done_o}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(rc_o == 1 && !pins_oe_o && !wr_valid_o && !done_o, "R1",
        {rc_o, pins_oe_o, wr_valid_o, done_o}, 4'b1000);

    tick(HI1 + LO + 2);
    chk(rc_o == 1 && !pins_oe_o && !wr_valid_o, "R11", {rc_o, pins_oe_o, wr_valid_o}, 3'b100);

    for (int pass = 0; pass < 2; pass++) begin
      run_phases();
      for (int v = 0; v < NV; v++) begin
        chk(wr_valid_o && wr_addr_o == VEC[v][27:20], (v == NV-1) ? "R7 addr" : "R6 addr",
            wr_addr_o, VEC[v][27:20]);
        chk(wr_data_o == VEC[v][19:4], (v == NV-1) ? "R7 data" : "R6 data",
            wr_data_o, VEC[v][19:4]);
        for (int d = 0; d < int'(VEC[v][3:0]); d++) begin
          @(negedge clk);
          if (d == 1) start_i = 1;
          else start_i = 0;
          chk(wr_valid_o && wr_addr_o == VEC[v][27:20] && wr_data_o == VEC[v][19:4],
              "R8 R10 hold", wr_addr_o, VEC[v][27:20]);
        end
        start_i = 0;
        @(negedge clk) wr_done_i = 1;
        chk(!done_o, "R9 early", done_o, 0);
        @(negedge clk) wr_done_i = 0;
        if (v == NV-1)
          chk(done_o && !wr_valid_o, "R9", {done_o, wr_valid_o}, 2'b10);
      end
      @(negedge clk);
      chk(!done_o && !wr_valid_o && rc_o && !pins_oe_o, "R9 R5",
          {done_o, wr_valid_o, rc_o, pins_oe_o}, 4'b0010);
      tick(2);
      chk(rc_o && !wr_valid_o && !pins_oe_o, "R11", {rc_o, wr_valid_o, pins_oe_o}, 3'b100);
    end
    finish_run();
  end
endmodule